// File: doc/BRIEF.md
# Non-Destructive Memory Size Prober

This block discovers how much memory sits behind a simple word-wide read/write bus without disturbing the data it holds. After a start pulse it saves the first two words of the space. It then runs a two-phase presence test, with alternating patterns written to a neighbouring word so that a floating bus that merely remembers the last value driven on it is not mistaken for storage. Finally it doubles a test offset and looks for the point where the address space wraps back onto word 0.

Only the words at byte offsets 0 and 4 are ever written, and both are put back before completion. Battery-backed or otherwise precious contents higher in the space are therefore never touched. The result is a byte count: 0 when no working memory answers, the wrap offset when one is found, or the caller's power-of-two maximum when no wrap appears below it.

Top module: `mem_size_prober`

## Requirements
- R1: After reset, `done` and `memValid` are low and `sizeOut` is 0.
- R2: The words at byte offsets 0 and 4 are read before any write and written back before `done`, so after a run every word of the memory holds its value from before the run.
- R3: Every write the block issues targets byte address 0 or 4.
- R4: Presence phase one writes 32'h5555AAAA to offset 0, then 32'hAAAA5555 to offset 4, then reads offset 0; a mismatch gives size 0 (a bus that returns the last written value is reported as size 0).
- R5: Presence phase two swaps the patterns (32'hAAAA5555 at offset 0, 32'h5555AAAA at offset 4) and rereads offset 0; a mismatch gives size 0 (a memory with data bit 0 stuck at 0 is reported as size 0).
- R6: Sizing starts at byte offset 4 and doubles. At each offset the block reads the test word, writes its bitwise inverse to offset 0, then reads offset 0 and the test offset again; if they are equal the size is that offset. A memory of N bytes with N below the maximum therefore reports N.
- R7: When the doubled offset reaches `maxSize` without a wrap, the result is `maxSize`.
- R8: A memory of one word, where offset 4 aliases offset 0, fails the presence check and reports 0.
- R9: Once `memValid` is high it stays high with `memWrite`, `memAddr` and `memWdata` unchanged until a cycle with `memReady` high.
- R10: `done` is high for exactly one cycle per run. `sizeOut` is 0 or a power of two at that point and stays unchanged until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a probe (ignored while busy) |
| maxSize | input | ADDR_W+1 | Largest size to probe in bytes, a power of two of at least 8 |
| done | output | 1 | One-cycle completion pulse |
| sizeOut | output | ADDR_W+1 | Detected size in bytes, 0 for none |
| memValid | output | 1 | Bus request |
| memWrite | output | 1 | 1 for write, 0 for read |
| memAddr | output | ADDR_W | Byte address |
| memWdata | output | DATA_W | Write data |
| memReady | input | 1 | Access completes in this cycle |
| memRdata | input | DATA_W | Read data, valid with memReady |

## Verification
Two situations are hard to reach from the ports. The first is a bus that echoes back the last value driven on it. The second is a memory that passes the first pattern but fails the swapped one. The bench's memory model has a mode for each: in one it returns the last write data when no storage is present, and in the other it forces data bit 0 low. It also folds every address modulo a chosen power-of-two size, so wrap detection is swept over every size from one word to 4 KB against several maxima, under varying ready latency.

// File: rtl/prober_pkg.sv
package prober_pkg;

  typedef enum logic [1:0] {
    SEL_W0,
    SEL_W1,
    SEL_TEST
  } addrSel_e;

  typedef enum logic [2:0] {
    DAT_PAT_A,
    DAT_PAT_B,
    DAT_INV,
    DAT_SAVE0,
    DAT_SAVE1
  } dataSel_e;

  typedef struct packed {
    addrSel_e aSel;
    dataSel_e dSel;
    logic     capSave0;
    logic     capSave1;
    logic     capTest;
    logic     capZero;
    logic     ofsInit;
    logic     ofsShift;
    logic     sizeClr;
    logic     sizeOfs;
    logic     sizeMax;
  } strobes_t;

  typedef struct packed {
    logic matchA;
    logic matchB;
    logic aliasHit;
    logic atMax;
    logic nextAtMax;
  } flags_t;

endpackage

// File: rtl/prober_ctrl.sv
module prober_ctrl
  import prober_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     memReady,
  input  flags_t   flags,
  output strobes_t strobes,
  output logic     memValid,
  output logic     memWrite,
  output logic     done
);

  typedef enum logic [4:0] {
    ST_IDLE, ST_RD_S0, ST_RD_S1, ST_WR_A0, ST_WR_B1, ST_CHK_A,
    ST_WR_B0, ST_WR_A1, ST_CHK_B, ST_RD_T, ST_WR_INV, ST_RD_Z,
    ST_RD_T2, ST_RST0, ST_RST1, ST_FIN
  } state_e;

  state_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strobes   = '0;
    memValid  = 1'b0;
    memWrite  = 1'b0;
    done      = 1'b0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (start) begin
          strobes.sizeClr = 1'b1;
          strobes.ofsInit = 1'b1;
          nextState = ST_RD_S0;
        end
      end
      ST_RD_S0: begin
        memValid = 1'b1;
        strobes.aSel = SEL_W0;
        if (memReady) begin
          strobes.capSave0 = 1'b1;
          nextState = ST_RD_S1;
        end
      end
      ST_RD_S1: begin
        memValid = 1'b1;
        strobes.aSel = SEL_W1;
        if (memReady) begin
          strobes.capSave1 = 1'b1;
          nextState = ST_WR_A0;
        end
      end
      ST_WR_A0: begin
        memValid = 1'b1;
        memWrite = 1'b1;
        strobes.aSel = SEL_W0;
        strobes.dSel = DAT_PAT_A;
        if (memReady) nextState = ST_WR_B1;
      end
      ST_WR_B1: begin
        memValid = 1'b1;
        memWrite = 1'b1;
        strobes.aSel = SEL_W1;
        strobes.dSel = DAT_PAT_B;
        if (memReady) nextState = ST_CHK_A;
      end
      ST_CHK_A: begin
        memValid = 1'b1;
        strobes.aSel = SEL_W0;
        if (memReady) nextState = flags.matchA ? ST_WR_B0 : ST_RST0;
      end
      ST_WR_B0: begin
        memValid = 1'b1;
        memWrite = 1'b1;
        strobes.aSel = SEL_W0;
        strobes.dSel = DAT_PAT_B;
        if (memReady) nextState = ST_WR_A1;
      end
      ST_WR_A1: begin
        memValid = 1'b1;
        memWrite = 1'b1;
        strobes.aSel = SEL_W1;
        strobes.dSel = DAT_PAT_A;
        if (memReady) nextState = ST_CHK_B;
      end
      ST_CHK_B: begin
        memValid = 1'b1;
        strobes.aSel = SEL_W0;
        if (memReady) begin
          if (!flags.matchB) begin
            nextState = ST_RST0;
          end else if (flags.atMax) begin
            strobes.sizeMax = 1'b1;
            nextState = ST_RST0;
          end else begin
            nextState = ST_RD_T;
          end
        end
      end
      ST_RD_T: begin
        memValid = 1'b1;
        strobes.aSel = SEL_TEST;
        if (memReady) begin
          strobes.capTest = 1'b1;
          nextState = ST_WR_INV;
        end
      end
      ST_WR_INV: begin
        memValid = 1'b1;
        memWrite = 1'b1;
        strobes.aSel = SEL_W0;
        strobes.dSel = DAT_INV;
        if (memReady) nextState = ST_RD_Z;
      end
      ST_RD_Z: begin
        memValid = 1'b1;
        strobes.aSel = SEL_W0;
        if (memReady) begin
          strobes.capZero = 1'b1;
          nextState = ST_RD_T2;
        end
      end
      ST_RD_T2: begin
        memValid = 1'b1;
        strobes.aSel = SEL_TEST;
        if (memReady) begin
          if (flags.aliasHit) begin
            strobes.sizeOfs = 1'b1;
            nextState = ST_RST0;
          end else if (flags.nextAtMax) begin
            strobes.sizeMax = 1'b1;
            nextState = ST_RST0;
          end else begin
            strobes.ofsShift = 1'b1;
            nextState = ST_RD_T;
          end
        end
      end
      ST_RST0: begin
        memValid = 1'b1;
        memWrite = 1'b1;
        strobes.aSel = SEL_W0;
        strobes.dSel = DAT_SAVE0;
        if (memReady) nextState = ST_RST1;
      end
      ST_RST1: begin
        memValid = 1'b1;
        memWrite = 1'b1;
        strobes.aSel = SEL_W1;
        strobes.dSel = DAT_SAVE1;
        if (memReady) nextState = ST_FIN;
      end
      ST_FIN: begin
        done = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/prober_dpath.sv
module prober_dpath
  import prober_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobes,
  input  logic [ADDR_W:0]   maxSize,
  input  logic [DATA_W-1:0] memRdata,
  output flags_t            flags,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [ADDR_W:0]   sizeOut
);

  localparam int SIZE_W = ADDR_W + 1;
  localparam int WORD_BYTES = DATA_W / 8;
  localparam int REPS = DATA_W / 32;
  localparam logic [DATA_W-1:0] PAT_A = {REPS{32'h5555AAAA}};
  localparam logic [DATA_W-1:0] PAT_B = {REPS{32'hAAAA5555}};
  localparam logic [ADDR_W-1:0] W1_ADDR = ADDR_W'(WORD_BYTES);

  logic [DATA_W-1:0] save0, save1, testWord, zeroWord;
  logic [SIZE_W-1:0] ofs;
  logic [SIZE_W:0]   ofsNext;

  assign ofsNext = {ofs, 1'b0};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      save0    <= '0;
      save1    <= '0;
      testWord <= '0;
      zeroWord <= '0;
      ofs      <= '0;
      sizeOut  <= '0;
    end else begin
      if (strobes.capSave0) save0 <= memRdata;
      if (strobes.capSave1) save1 <= memRdata;
      if (strobes.capTest)  testWord <= memRdata;
      if (strobes.capZero)  zeroWord <= memRdata;
      if (strobes.ofsInit)       ofs <= SIZE_W'(WORD_BYTES);
      else if (strobes.ofsShift) ofs <= ofsNext[SIZE_W-1:0];
      if (strobes.sizeClr)      sizeOut <= '0;
      else if (strobes.sizeOfs) sizeOut <= ofs;
      else if (strobes.sizeMax) sizeOut <= maxSize;
    end
  end

  always_comb begin
    case (strobes.aSel)
      SEL_W0:   memAddr = '0;
      SEL_W1:   memAddr = W1_ADDR;
      SEL_TEST: memAddr = ofs[ADDR_W-1:0];
      default:  memAddr = '0;
    endcase
  end

  always_comb begin
    case (strobes.dSel)
      DAT_PAT_A: memWdata = PAT_A;
      DAT_PAT_B: memWdata = PAT_B;
      DAT_INV:   memWdata = ~testWord;
      DAT_SAVE0: memWdata = save0;
      DAT_SAVE1: memWdata = save1;
      default:   memWdata = '0;
    endcase
  end

  assign flags.matchA    = (memRdata == PAT_A);
  assign flags.matchB    = (memRdata == PAT_B);
  assign flags.aliasHit  = (memRdata == zeroWord);
  assign flags.atMax     = (ofs >= maxSize);
  assign flags.nextAtMax = (ofsNext >= {1'b0, maxSize});

endmodule

// File: rtl/mem_size_prober.sv
module mem_size_prober
  import prober_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W:0]   maxSize,
  output logic              done,
  output logic [ADDR_W:0]   sizeOut,
  output logic              memValid,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memReady,
  input  logic [DATA_W-1:0] memRdata
);

  strobes_t strobes;
  flags_t   flags;

  prober_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .memReady (memReady),
    .flags    (flags),
    .strobes  (strobes),
    .memValid (memValid),
    .memWrite (memWrite),
    .done     (done)
  );

  prober_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .maxSize  (maxSize),
    .memRdata (memRdata),
    .flags    (flags),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .sizeOut  (sizeOut)
  );

endmodule

// File: rtl/prober_chk.sv
module prober_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              done,
  input logic [ADDR_W:0]   sizeOut,
  input logic              memValid,
  input logic              memWrite,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memWdata,
  input logic              memReady
);

  localparam logic [ADDR_W-1:0] W1_ADDR = ADDR_W'(DATA_W / 8);

  // R3
  write_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memWrite) |-> (memAddr == '0 || memAddr == W1_ADDR));

  // R9
  request_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> (memValid && $stable(memWrite) &&
                                 $stable(memAddr) && $stable(memWdata)));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10
  size_pow2_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $onehot0(sizeOut));

  // R10
  size_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!start && !memValid) |=> $stable(sizeOut));

endmodule

bind mem_size_prober prober_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .done     (done),
  .sizeOut  (sizeOut),
  .memValid (memValid),
  .memWrite (memWrite),
  .memAddr  (memAddr),
  .memWdata (memWdata),
  .memReady (memReady)
);

// File: tb/test_mem_size_prober.sv
`timescale 1ns/1ps
module test_mem_size_prober;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int WORDS  = 1024;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [ADDR_W:0]   maxSize = 17'd4096;
  logic              done;
  logic [ADDR_W:0]   sizeOut;
  logic              memValid, memWrite;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memWdata;
  logic              memReady = 1'b0;
  logic [DATA_W-1:0] memRdata = '0;

  int errors = 0;
  int checks = 0;

  logic [31:0] mem [WORDS];
  int          memBytes = 4096;
  bit          absentMode = 1'b0;
  bit          stuckMode = 1'b0;
  logic [31:0] lastBus = '0;
  int          waitCnt = 0;
  int          lat = 0;
  logic [7:0]  lfsr = 8'h5A;
  int          highWrites = 0;
  int          doneCnt = 0;

  always #5 clk = ~clk;

  mem_size_prober #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_mem_size_prober (
    .clk(clk), .rstN(rstN), .start(start), .maxSize(maxSize),
    .done(done), .sizeOut(sizeOut), .memValid(memValid), .memWrite(memWrite),
    .memAddr(memAddr), .memWdata(memWdata), .memReady(memReady),
    .memRdata(memRdata));

  // memory model: responds at falling edges, one-cycle ready per access
  always @(negedge clk) begin
    if (done) doneCnt = doneCnt + 1;
    if (memReady) begin
      memReady = 1'b0;
    end else if (memValid) begin
      if (waitCnt >= lat) begin
        int idx;
        idx = (int'(memAddr) & (memBytes - 1)) >> 2;
        if (memWrite) begin
          if (memAddr >= 8) highWrites = highWrites + 1;
          lastBus = memWdata;
          if (!absentMode) mem[idx] = memWdata;
        end else begin
          if (absentMode)     memRdata = lastBus;
          else if (stuckMode) memRdata = mem[idx] & ~32'h1;
          else                memRdata = mem[idx];
        end
        memReady = 1'b1;
        waitCnt = 0;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        lat = int'(lfsr[1:0]) % 3;
      end else begin
        waitCnt = waitCnt + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] seed(input int i, input int run);
    return 32'h9E3779B9 * (i + 1) ^ (32'(run) << 20);
  endfunction

  task automatic runProbe(input int mb, input int mx, input bit absent,
                          input bit stuck, input int run);
    int expSize;
    int t;
    bit corrupt;
    memBytes = mb;
    absentMode = absent;
    stuckMode = stuck;
    maxSize = 17'(mx);
    for (int i = 0; i < WORDS; i++) mem[i] = seed(i, run);
    highWrites = 0;
    doneCnt = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t = 0;
    while (doneCnt == 0 && t < 5000) begin
      @(negedge clk);
      t++;
    end
    repeat (4) @(negedge clk);
    if (absent || stuck || mb == 4) expSize = 0;
    else expSize = (mb < mx) ? mb : mx;
    if (absent)      check(int'(sizeOut) == expSize, "R4", sizeOut, expSize);
    else if (stuck)  check(int'(sizeOut) == expSize, "R5", sizeOut, expSize);
    else if (mb == 4) check(int'(sizeOut) == expSize, "R8", sizeOut, expSize);
    else if (mb < mx) check(int'(sizeOut) == expSize, "R6", sizeOut, expSize);
    else             check(int'(sizeOut) == expSize, "R7", sizeOut, expSize);
    check(doneCnt == 1, "R10", doneCnt, 1);
    check(highWrites == 0, "R3", highWrites, 0);
    if (!absent && !stuck) begin
      corrupt = 1'b0;
      for (int i = 0; i < mb / 4; i++)
        if (mem[i] != seed(i, run)) corrupt = 1'b1;
      check(!corrupt, "R2", corrupt, 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int run;
    run = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(done == 1'b0, "R1", done, 0);
    check(memValid == 1'b0, "R1", memValid, 0);
    check(sizeOut == '0, "R1", sizeOut, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    // sweep memory sizes against several maxima (R6, R7, R8)
    for (int mxSel = 0; mxSel < 3; mxSel++) begin
      int mx;
      mx = (mxSel == 0) ? 8 : (mxSel == 1) ? 256 : 4096;
      for (int sh = 2; sh <= 12; sh++) begin
        runProbe(1 << sh, mx, 1'b0, 1'b0, run);
        run++;
      end
    end
    // floating bus, R4
    runProbe(4096, 4096, 1'b1, 1'b0, run); run++;
    runProbe(64, 256, 1'b1, 1'b0, run); run++;
    // stuck bit, R5
    runProbe(1024, 4096, 1'b0, 1'b1, run); run++;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule